// File: doc/BRIEF.md
# Precharged RAM Access Sequencer

This block sits on the host side of a static RAM whose bit lines must be precharged before every access, and whose read and write strobes are separate. It takes one request at a time through a valid/ready handshake. Each request carries an address, a data word and a direction. The block then walks the RAM pins through a fixed order of phases: it presents the address, pulses the active-low precharge strobe, raises the access strobe together with either the write or the read strobe, and finally drops all strobes and lets go of the data bus.

On a write, the sequencer drives the request data onto the RAM data bus during the access phase. Only the low `DW` bits are used, and any upper request bits are discarded. On a read, it leaves the bus undriven and samples the returned word at the end of the access phase. When the request asks for a check, it also compares that word with the request data, which then serves as the expected value. One clock is one phase, so a request that is accepted on one edge completes five edges later with a single-cycle done pulse.

The states are: `ST_INIT` (bus driven low from reset until the first edge after reset), `ST_IDLE` (ready), `ST_ADDR` (address set up), `ST_PRE` (precharge low), `ST_RECOV` (precharge back high), `ST_ACC` (access with one strobe) and `ST_REL` (strobes dropped, bus free, done). The transitions are INIT→IDLE on the first edge, IDLE→ADDR on a handshake, then ADDR→PRE→RECOV→ACC→REL→IDLE, one step per edge with no conditions.

Top module: `pcram_seq`

## Requirements
- R1: While reset is low, and until the first clock edge after its release, `ram_pre_n` is 1, `ram_access`, `ram_wr`, `ram_rd` and `req_ready` are 0, and `ram_dq_oe` is 1 with `ram_dq_out` all zero. In the cycle after that edge, `ram_dq_oe` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in the idle state. A request is taken on an edge where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the sequence ends.
- R3: In the first cycle after acceptance, `ram_addr` equals the request address and `ram_pre_n` is 1 with no strobe active. The address stays unchanged through the release cycle.
- R4: `ram_pre_n` is 0 in exactly the second cycle after acceptance and is 1 again in the third. `ram_access` is 0 in both of these cycles.
- R5: `ram_access` is 1 only in the fourth cycle after acceptance, and there together with exactly one of `ram_wr` (write request) or `ram_rd` (read request). `ram_access` is never 1 while `ram_pre_n` is 0, and `ram_wr`/`ram_rd` are never 1 without `ram_access`.
- R6: In the access cycle of a write, `ram_dq_oe` is 1 and `ram_dq_out` equals bits [DW-1:0] of `req_wdata`. Outside `ST_INIT` and that cycle, `ram_dq_oe` is 0.
- R7: During a read access `ram_dq_oe` is 0. The value on `ram_dq_in` at the end of the access cycle appears on `rd_data` in the release cycle.
- R8: In the fifth cycle after acceptance, `ram_access`, `ram_wr`, `ram_rd` and `ram_dq_oe` are all 0 and `done` is 1 for that single cycle. In the next cycle `req_ready` is 1 again.
- R9: On a read with `req_check` = 1, `mismatch` is 1 in the release cycle exactly when the returned word differs from bits [DW-1:0] of `req_wdata`. A read with `req_check` = 0, or any write, gives `mismatch` = 0.
- R10: On a read with `req_check` = 1, `xerr` is 1 when any returned bit is unknown. It is 0 for fully known data and for all writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_check | input | 1 | Compare read data against `req_wdata` |
| req_addr | input | AW | Word address |
| req_wdata | input | REQ_W | Write data, or expected data on a read |
| ram_addr | output | AW | RAM address bus |
| ram_pre_n | output | 1 | Active-low bit-line precharge |
| ram_access | output | 1 | Access strobe |
| ram_wr | output | 1 | Write strobe |
| ram_rd | output | 1 | Read strobe |
| ram_dq_out | output | DW | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_in | input | DW | Data returned from the RAM |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read word |
| mismatch | output | 1 | Checked read differed from expected |
| xerr | output | 1 | Checked read contained unknown bits |

## Verification
The hardest case to reach from the ports is the change of bus direction in a single cycle. A write leaves the driver on in its access cycle, and the very next request may be a read of the same address that must find the driver off. The stimulus therefore alternates writes and checked reads back-to-back, across every address and with complementary data. It also includes checked reads whose expected word differs only in the discarded upper bits, and checked reads whose expected word is deliberately wrong. Every run of a read is scored against a model of the RAM contents that the bench keeps itself.

// File: rtl/pcram_pkg.sv
package pcram_pkg;
    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_PRE   = 3'd3,
        ST_RECOV = 3'd4,
        ST_ACC   = 3'd5,
        ST_REL   = 3'd6
    } seq_state_e;
endpackage

// File: rtl/pcram_req_reg.sv
module pcram_req_reg #(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int REQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_write,
    input  logic             in_check,
    input  logic [AW-1:0]    in_addr,
    input  logic [REQ_W-1:0] in_data,
    output logic             q_write,
    output logic             q_check,
    output logic [AW-1:0]    q_addr,
    output logic [DW-1:0]    q_data
);
    logic [DW-1:0] data_fit;

    // Width fitting of the request word onto the RAM data width
    generate
        if (REQ_W > DW) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^in_data[REQ_W-1:DW];
            assign data_fit  = in_data[DW-1:0];
        end else if (REQ_W < DW) begin : g_pad
            assign data_fit = {{(DW-REQ_W){1'b0}}, in_data};
        end else begin : g_same
            assign data_fit = in_data;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_check <= 1'b0;
            q_addr  <= '0;
            q_data  <= '0;
        end else if (load) begin
            q_write <= in_write;
            q_check <= in_check;
            q_addr  <= in_addr;
            q_data  <= data_fit;
        end
    end
endmodule

// File: rtl/pcram_fsm.sv
module pcram_fsm
    import pcram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       q_write,
    output seq_state_e state,
    output logic       req_ready,
    output logic       load,
    output logic       pre_n,
    output logic       access,
    output logic       wr,
    output logic       rd,
    output logic       dq_oe,
    output logic       drive_wdata,
    output logic       capture,
    output logic       done
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = ST_IDLE;
            ST_IDLE:  if (req_valid) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_PRE;
            ST_PRE:   state_d = ST_RECOV;
            ST_RECOV: state_d = ST_ACC;
            ST_ACC:   state_d = ST_REL;
            ST_REL:   state_d = ST_IDLE;
            default:  state_d = ST_INIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Outputs decoded from the current state
    always_comb begin
        req_ready   = 1'b0;
        pre_n       = 1'b1;
        access      = 1'b0;
        wr          = 1'b0;
        rd          = 1'b0;
        dq_oe       = 1'b0;
        drive_wdata = 1'b0;
        capture     = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_INIT:  dq_oe = 1'b1;
            ST_IDLE:  req_ready = 1'b1;
            ST_ADDR:  ;
            ST_PRE:   pre_n = 1'b0;
            ST_RECOV: ;
            ST_ACC: begin
                access      = 1'b1;
                wr          = q_write;
                rd          = !q_write;
                dq_oe       = q_write;
                drive_wdata = q_write;
                capture     = 1'b1;
            end
            ST_REL:   done = 1'b1;
            default:  ;
        endcase
    end

    assign load  = req_ready && req_valid;
    assign state = state_q;
endmodule

// File: rtl/pcram_rd_check.sv
module pcram_rd_check #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          q_write,
    input  logic          q_check,
    input  logic [DW-1:0] q_data,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rd_data,
    output logic          mismatch,
    output logic          xerr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            mismatch <= 1'b0;
            xerr     <= 1'b0;
        end else if (capture) begin
            if (q_write) begin
                mismatch <= 1'b0;
                xerr     <= 1'b0;
            end else begin
                rd_data  <= dq_in;
                mismatch <= q_check && (dq_in != q_data);
                xerr     <= q_check && $isunknown(dq_in);
            end
        end
    end
endmodule

// File: rtl/pcram_seq.sv
module pcram_seq
    import pcram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 8,
    parameter int REQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_check,
    input  logic [AW-1:0]    req_addr,
    input  logic [REQ_W-1:0] req_wdata,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_pre_n,
    output logic             ram_access,
    output logic             ram_wr,
    output logic             ram_rd,
    output logic [DW-1:0]    ram_dq_out,
    output logic             ram_dq_oe,
    input  logic [DW-1:0]    ram_dq_in,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic             mismatch,
    output logic             xerr
);
    seq_state_e    state;
    logic          load, drive_wdata, capture;
    logic          q_write, q_check;
    logic [DW-1:0] q_data;

    pcram_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .q_write     (q_write),
        .state       (state),
        .req_ready   (req_ready),
        .load        (load),
        .pre_n       (ram_pre_n),
        .access      (ram_access),
        .wr          (ram_wr),
        .rd          (ram_rd),
        .dq_oe       (ram_dq_oe),
        .drive_wdata (drive_wdata),
        .capture     (capture),
        .done        (done)
    );

    pcram_req_reg #(.AW(AW), .DW(DW), .REQ_W(REQ_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_write (req_write),
        .in_check (req_check),
        .in_addr  (req_addr),
        .in_data  (req_wdata),
        .q_write  (q_write),
        .q_check  (q_check),
        .q_addr   (ram_addr),
        .q_data   (q_data)
    );

    pcram_rd_check #(.DW(DW)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .q_write  (q_write),
        .q_check  (q_check),
        .q_data   (q_data),
        .dq_in    (ram_dq_in),
        .rd_data  (rd_data),
        .mismatch (mismatch),
        .xerr     (xerr)
    );

    // Write data only in the write access phase; zeros otherwise
    assign ram_dq_out = drive_wdata ? q_data : '0;

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/pcram_seq_sva.sv
module pcram_seq_sva #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] ram_addr,
    input logic          ram_pre_n,
    input logic          ram_access,
    input logic          ram_wr,
    input logic          ram_rd,
    input logic          ram_dq_oe,
    input logic          done
);
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_pre_n && !ram_access && !done)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_access || done) |-> $stable(ram_addr)); // R3
    AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_pre_n) |=> ram_pre_n); // R4
    AST_ACCEPT_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ram_pre_n ##1 !ram_pre_n); // R4
    AST_NO_ACCESS_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_access && !ram_pre_n)); // R5
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_access |-> ($countones({ram_wr, ram_rd}) == 1)); // R5
    AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr || ram_rd) |-> ram_access); // R5
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ram_dq_oe); // R6
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> !ram_dq_oe); // R7
    AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ram_access) && !ram_access && !ram_dq_oe)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R8
endmodule

bind pcram_seq pcram_seq_sva #(.AW(AW), .DW(DW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ram_addr   (ram_addr),
    .ram_pre_n  (ram_pre_n),
    .ram_access (ram_access),
    .ram_wr     (ram_wr),
    .ram_rd     (ram_rd),
    .ram_dq_oe  (ram_dq_oe),
    .done       (done)
);

// File: tb/pcram_seq_tb.sv
module pcram_seq_tb;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int REQ_W = 16;
    localparam int NWORDS = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_check = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [REQ_W-1:0] req_wdata = '0;
    logic             req_ready, ram_pre_n, ram_access, ram_wr, ram_rd, ram_dq_oe;
    logic             done, mismatch, xerr;
    logic [AW-1:0]    ram_addr;
    logic [DW-1:0]    ram_dq_out, ram_dq_in, rd_data;

    logic [DW-1:0] ram_mem [NWORDS];
    logic [DW-1:0] model [NWORDS];
    logic [DW:0]   exp_q [$];
    int n_checks = 0;
    int n_errors = 0;
    bit pend_rd = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pcram_seq #(.AW(AW), .DW(DW), .REQ_W(REQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_check(req_check), .req_addr(req_addr),
        .req_wdata(req_wdata), .ram_addr(ram_addr), .ram_pre_n(ram_pre_n),
        .ram_access(ram_access), .ram_wr(ram_wr), .ram_rd(ram_rd),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in),
        .done(done), .rd_data(rd_data), .mismatch(mismatch), .xerr(xerr)
    );

    // RAM model: stores on a write strobe, returns the word on a read strobe
    assign ram_dq_in = (ram_access && ram_rd) ? ram_mem[ram_addr] : '0;
    always @(posedge clk)
        if (ram_access && ram_wr && ram_dq_oe) ram_mem[ram_addr] <= ram_dq_out;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_acc(input bit wr, input logic [AW-1:0] a,
                          input logic [REQ_W-1:0] d, input bit ck);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_check = ck;
        req_addr = a; req_wdata = d;
        if (wr) model[a] = d[DW-1:0];
        else exp_q.push_back({ck && (model[a] != d[DW-1:0]), model[a]});
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk("R3 addr presented", 32'(ram_addr), 32'(a));
        chk("R3 no strobe", {ram_pre_n, ram_access, ram_wr, ram_rd}, 4'b1000);
        chk("R2 busy", 32'(req_ready), 0);
        @(negedge clk);
        chk("R4 precharge low", {ram_pre_n, ram_access}, 2'b00);
        @(negedge clk);
        chk("R4 precharge high", {ram_pre_n, ram_access}, 2'b10);
        @(negedge clk);
        chk("R5 access strobes", {ram_access, ram_wr, ram_rd}, {1'b1, wr, !wr});
        chk("R3 addr held", 32'(ram_addr), 32'(a));
        if (wr) begin
            chk("R6 driver on", 32'(ram_dq_oe), 1);
            chk("R6 masked write data", 32'(ram_dq_out), 32'(d[DW-1:0]));
        end else begin
            chk("R7 driver off", 32'(ram_dq_oe), 0);
        end
        @(negedge clk);
        chk("R8 release", {ram_access, ram_wr, ram_rd, ram_dq_oe, done}, 5'b00001);
        chk("R3 addr held in release", 32'(ram_addr), 32'(a));
        if (wr) chk("R9 R10 flags clear on write", {mismatch, xerr}, 2'b00);
        @(negedge clk);
        chk("R8 ready again", {req_ready, done}, 2'b10);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && ram_access && ram_rd) pend_rd <= 1'b1;
        if (rst_n && done && pend_rd) begin
            pend_rd <= 1'b0;
            if (exp_q.size() == 0) begin
                chk("R7 unexpected read result", 1, 0);
            end else begin
                logic [DW:0] e;
                e = exp_q.pop_front();
                chk("R7 read data", 32'(rd_data), 32'(e[DW-1:0]));
                chk("R9 mismatch", 32'(mismatch), 32'(e[DW]));
                chk("R10 xerr", 32'(xerr), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) begin
            ram_mem[i] = '0; model[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {ram_pre_n, ram_access, ram_wr, ram_rd, req_ready}, 5'b10000);
        chk("R1 reset bus drive", {ram_dq_oe, 8'(ram_dq_out)}, 9'h100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus released after reset", {ram_dq_oe, req_ready}, 2'b01);

        do_acc(1, 0, 16'h0000, 0);
        do_acc(1, 1, 16'h00FF, 0);
        do_acc(0, 0, 16'h0000, 1);
        do_acc(0, 1, 16'h00FF, 1);
        do_acc(0, 1, 16'h0000, 1);   // R9 deliberate mismatch
        do_acc(0, 1, 16'h0000, 0);   // R9 compare disabled
        do_acc(1, 2, 16'hA55A, 0);   // R6 upper bits dropped
        do_acc(0, 2, 16'h125A, 1);   // R9 masked compare
        // Full sweep with complementary data, write then read per address
        for (int a = 0; a < NWORDS; a++) begin
            logic [7:0] v;
            v = (a % 2 == 0) ? 8'(a * 37) : ~8'(a * 37);
            do_acc(1, AW'(a), {8'hC3, v}, 0);
            do_acc(0, AW'(a), {8'h00, v}, 1);
        end
        for (int a = NWORDS - 1; a >= 0; a--)
            do_acc(0, AW'(a), 16'h0055, (a % 3) == 0);
        repeat (3) @(negedge clk);
        chk("R7 scoreboard drained", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule